// File: doc/BRIEF.md
# Accumulator Bit-Slice Adder-Logic Unit

This block holds a 16-bit accumulator and a one-bit extension flag, and replaces the accumulator contents with one of several candidate values on a clock edge. The candidates are the bitwise AND of the accumulator with a data word, their sum with a carry input, a copy of the data word, an 8-bit input byte placed in the low half, the complement of the accumulator, and one-place shifts in either direction. The shifts rotate through the extension flag, so that flag and accumulator together form a 17-bit ring.

Each accumulator bit is computed by its own slice. A slice gates every candidate with its control and ORs the results. It takes its shift inputs from the neighbouring accumulator bits and passes an adder carry to the next slice. The end slices take the extension flag as their outer neighbour. Only the lower eight slices see the input byte. The carry out of the top slice feeds the extension flag.

Seven separate operation controls select the candidate, and a load enable commits it. A surrounding controller is expected to raise at most one operation control in a cycle where load is high. The decoder folds the control word into a named operation, which is one of IDLE, AND, ADD, COPY, BYTE, INVERT, ROTR or ROTL. IDLE covers the case where no control is high.

Top module: `acc_alu_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `ac_out` becomes 0 and `e_out` becomes 0 after that edge, whatever the other inputs are.
- R2: When `ld` is low at a rising edge (and `rst` is low), `ac_out` and `e_out` keep their values, whatever the operation controls and data inputs are.
- R3: With `ld` high and only `op_and` high, `ac_out` becomes `ac_out & dr_in`, and `e_out` is unchanged.
- R4: With `ld` high and only `op_add` high, the 17-bit value {`e_out`,`ac_out`} becomes `ac_out + dr_in + carry_in`. The carry out of bit 15 lands in `e_out`.
- R5: With `ld` high and only `op_dr` high, `ac_out` becomes `dr_in`, and `e_out` is unchanged.
- R6: With `ld` high and only `op_inpr` high, `ac_out[7:0]` becomes `inpr_in`, `ac_out[15:8]` becomes 0, and `e_out` is unchanged.
- R7: With `ld` high and only `op_com` high, `ac_out` becomes `~ac_out`, and `e_out` is unchanged.
- R8: With `ld` high and only `op_shr` high, bit i takes old bit i+1, bit 15 takes old `e_out`, and `e_out` takes old bit 0.
- R9: With `ld` high and only `op_shl` high, bit i takes old bit i-1, bit 0 takes old `e_out`, and `e_out` takes old bit 15.
- R10: With `ld` high and no operation control high, `ac_out` becomes 0 and `e_out` is unchanged. Patterns with more than one control high while `ld` is high are illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of accumulator and flag |
| ld | input | 1 | Commit the selected candidate on this edge |
| op_and | input | 1 | Select accumulator AND data word |
| op_add | input | 1 | Select accumulator plus data word plus carry input |
| op_dr | input | 1 | Select copy of data word |
| op_inpr | input | 1 | Select input byte into the low half, upper half cleared |
| op_com | input | 1 | Select complement of accumulator |
| op_shr | input | 1 | Select rotate right through the flag |
| op_shl | input | 1 | Select rotate left through the flag |
| carry_in | input | 1 | Carry into the lowest adder stage |
| dr_in | input | 16 | Data word operand |
| inpr_in | input | 8 | Input byte operand |
| ac_out | output | 16 | Accumulator contents |
| e_out | output | 1 | Extension flag contents |

## Verification
The assertions assume that, in any cycle where `ld` is high, at most one of the seven operation controls is high. They also assume that inputs are settled at the rising edge. A guard property flags any multi-hot control word under load, and each per-operation property fires only when its own control is the sole one high. The bench drives every input on the falling edge and only ever presents an empty control word or a single-hot one. So the guard stays quiet, and each check compares against a result that is fully defined.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int CTL_W = 7;

    // bit positions of the control word {shl,shr,com,inpr,dr,add,and}
    localparam logic [CTL_W-1:0] HOT_AND  = 7'b000_0001;
    localparam logic [CTL_W-1:0] HOT_ADD  = 7'b000_0010;
    localparam logic [CTL_W-1:0] HOT_COPY = 7'b000_0100;
    localparam logic [CTL_W-1:0] HOT_BYTE = 7'b000_1000;
    localparam logic [CTL_W-1:0] HOT_INV  = 7'b001_0000;
    localparam logic [CTL_W-1:0] HOT_ROTR = 7'b010_0000;
    localparam logic [CTL_W-1:0] HOT_ROTL = 7'b100_0000;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_AND,
        OP_ADD,
        OP_COPY,
        OP_BYTE,
        OP_INVERT,
        OP_ROTR,
        OP_ROTL
    } op_e;

    typedef struct packed {
        logic g_and;
        logic g_add;
        logic g_copy;
        logic g_byte;
        logic g_inv;
        logic g_rotr;
        logic g_rotl;
    } gates_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    output op_e              op,
    output gates_t           gates
);

    always_comb begin
        unique case (ctl)
            HOT_AND:  op = OP_AND;
            HOT_ADD:  op = OP_ADD;
            HOT_COPY: op = OP_COPY;
            HOT_BYTE: op = OP_BYTE;
            HOT_INV:  op = OP_INVERT;
            HOT_ROTR: op = OP_ROTR;
            HOT_ROTL: op = OP_ROTL;
            default:  op = OP_IDLE;
        endcase
    end

    always_comb begin
        gates = '0;
        unique case (op)
            OP_AND:    gates.g_and  = 1'b1;
            OP_ADD:    gates.g_add  = 1'b1;
            OP_COPY:   gates.g_copy = 1'b1;
            OP_BYTE:   gates.g_byte = 1'b1;
            OP_INVERT: gates.g_inv  = 1'b1;
            OP_ROTR:   gates.g_rotr = 1'b1;
            OP_ROTL:   gates.g_rotl = 1'b1;
            OP_IDLE:   gates        = '0;
        endcase
    end

endmodule

// File: rtl/acc_alu_slice.sv
module acc_alu_slice
    import acc_alu_pkg::*;
(
    input  gates_t gates,
    input  logic   ac_self,
    input  logic   from_hi,
    input  logic   from_lo,
    input  logic   dr_bit,
    input  logic   inpr_bit,
    input  logic   cin,
    output logic   nxt,
    output logic   cout
);

    logic half;
    logic sum;

    assign half = ac_self ^ dr_bit;
    assign sum  = half ^ cin;
    assign cout = (ac_self & dr_bit) | (cin & half);

    assign nxt = (gates.g_and  & ac_self & dr_bit)
               | (gates.g_add  & sum)
               | (gates.g_copy & dr_bit)
               | (gates.g_byte & inpr_bit)
               | (gates.g_inv  & ~ac_self)
               | (gates.g_rotr & from_hi)
               | (gates.g_rotl & from_lo);

endmodule

// File: rtl/acc_alu_eflag.sv
module acc_alu_eflag
    import acc_alu_pkg::*;
(
    input  op_e  op,
    input  logic carry_top,
    input  logic ac_lsb,
    input  logic ac_msb,
    input  logic e_cur,
    output logic e_nxt
);

    always_comb begin
        unique case (op)
            OP_ADD:  e_nxt = carry_top;
            OP_ROTR: e_nxt = ac_lsb;
            OP_ROTL: e_nxt = ac_msb;
            default: e_nxt = e_cur;
        endcase
    end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int AC_W   = 16,
    parameter int INPR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic              op_and,
    input  logic              op_add,
    input  logic              op_dr,
    input  logic              op_inpr,
    input  logic              op_com,
    input  logic              op_shr,
    input  logic              op_shl,
    input  logic              carry_in,
    input  logic [AC_W-1:0]   dr_in,
    input  logic [INPR_W-1:0] inpr_in,
    output logic [AC_W-1:0]   ac_out,
    output logic              e_out
);

    localparam int EXT_W = AC_W + 2;

    logic [CTL_W-1:0] ctl_vec;
    op_e              op;
    gates_t           gates;
    logic [AC_W-1:0]  ac_q;
    logic             e_q;
    logic [AC_W-1:0]  ac_nxt;
    logic             e_nxt;
    logic [AC_W:0]    carry;
    logic [EXT_W-1:0] ring;

    assign ctl_vec = {op_shl, op_shr, op_com, op_inpr, op_dr, op_add, op_and};
    assign ring    = {e_q, ac_q, e_q};
    assign carry[0] = carry_in;

    acc_alu_decode u_decode (
        .ctl   (ctl_vec),
        .op    (op),
        .gates (gates)
    );

    for (genvar i = 0; i < AC_W; i++) begin : g_bit
        logic inpr_b;
        if (i < INPR_W) begin : g_byte
            assign inpr_b = inpr_in[i];
        end else begin : g_nobyte
            assign inpr_b = 1'b0;
        end
        acc_alu_slice u_slice (
            .gates    (gates),
            .ac_self  (ring[i+1]),
            .from_hi  (ring[i+2]),
            .from_lo  (ring[i]),
            .dr_bit   (dr_in[i]),
            .inpr_bit (inpr_b),
            .cin      (carry[i]),
            .nxt      (ac_nxt[i]),
            .cout     (carry[i+1])
        );
    end

    acc_alu_eflag u_eflag (
        .op        (op),
        .carry_top (carry[AC_W]),
        .ac_lsb    (ac_q[0]),
        .ac_msb    (ac_q[AC_W-1]),
        .e_cur     (e_q),
        .e_nxt     (e_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q <= '0;
            e_q  <= 1'b0;
        end else if (ld) begin
            ac_q <= ac_nxt;
            e_q  <= e_nxt;
        end
    end

    assign ac_out = ac_q;
    assign e_out  = e_q;

    // ---------------- assertions ----------------
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ac_out == '0 && e_out == 1'b0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ld |=> ($stable(ac_out) && $stable(e_out)));

    assert_and_R3: assert property (@(posedge clk) disable iff (rst)
        (ld && ctl_vec == HOT_AND) |=>
        (ac_out == ($past(ac_out) & $past(dr_in)) && e_out == $past(e_out)));

    assert_add_R4: assert property (@(posedge clk) disable iff (rst)
        (ld && ctl_vec == HOT_ADD) |=>
        ({e_out, ac_out} == ({1'b0, $past(ac_out)} + {1'b0, $past(dr_in)}
                             + {{AC_W{1'b0}}, $past(carry_in)})));

    assert_copy_R5: assert property (@(posedge clk) disable iff (rst)
        (ld && ctl_vec == HOT_COPY) |=>
        (ac_out == $past(dr_in) && e_out == $past(e_out)));

    assert_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (ld && ctl_vec == HOT_BYTE) |=>
        (ac_out == {{(AC_W-INPR_W){1'b0}}, $past(inpr_in)} && e_out == $past(e_out)));

    assert_invert_R7: assert property (@(posedge clk) disable iff (rst)
        (ld && ctl_vec == HOT_INV) |=>
        (ac_out == ~$past(ac_out) && e_out == $past(e_out)));

    assert_rotr_R8: assert property (@(posedge clk) disable iff (rst)
        (ld && ctl_vec == HOT_ROTR) |=>
        ({ac_out, e_out} == {$past(e_out), $past(ac_out)}));

    assert_rotl_R9: assert property (@(posedge clk) disable iff (rst)
        (ld && ctl_vec == HOT_ROTL) |=>
        ({e_out, ac_out} == {$past(ac_out), $past(e_out)}));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (ld && ctl_vec == '0) |=>
        (ac_out == '0 && e_out == $past(e_out)));

    assert_ctl_single_R10: assert property (@(posedge clk) disable iff (rst)
        ld |-> $onehot0(ctl_vec));

endmodule

// File: tb/acc_alu_unit_bench.sv
module acc_alu_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    // control word encoding used by the bench: {shl,shr,com,inpr,dr,add,and}
    localparam logic [6:0] C_AND = 7'b000_0001;
    localparam logic [6:0] C_ADD = 7'b000_0010;
    localparam logic [6:0] C_DR  = 7'b000_0100;
    localparam logic [6:0] C_IN  = 7'b000_1000;
    localparam logic [6:0] C_COM = 7'b001_0000;
    localparam logic [6:0] C_SHR = 7'b010_0000;
    localparam logic [6:0] C_SHL = 7'b100_0000;

    localparam logic [6:0]  V_CTL [NV] = '{C_DR, C_ADD, C_SHL, C_SHR, C_COM,
                                           C_IN, C_AND, C_ADD, 7'b0, C_SHR};
    localparam logic [15:0] V_DR  [NV] = '{16'h1234, 16'hFFFF, 16'h0F0F, 16'hAAAA, 16'h5555,
                                           16'h0000, 16'hFF0F, 16'h0001, 16'hFFFF, 16'h8001};
    localparam logic [7:0]  V_IN  [NV] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55,
                                           8'hA5, 8'h77, 8'h88, 8'h99, 8'hCC};
    localparam logic        V_CIN [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
                                           1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam string       V_REQ [NV] = '{"R5", "R4", "R9", "R8", "R7",
                                           "R6", "R3", "R4", "R10", "R8"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld = 1'b0;
    logic [6:0]  ctl = '0;
    logic        cin = 1'b0;
    logic [15:0] dr = '0;
    logic [7:0]  inpr = '0;
    logic [15:0] ac;
    logic        e;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;
    logic [15:0] m_ac;
    logic        m_e;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu_unit u_acc_alu_unit (
        .clk      (clk),
        .rst      (rst),
        .ld       (ld),
        .op_and   (ctl[0]),
        .op_add   (ctl[1]),
        .op_dr    (ctl[2]),
        .op_inpr  (ctl[3]),
        .op_com   (ctl[4]),
        .op_shr   (ctl[5]),
        .op_shl   (ctl[6]),
        .carry_in (cin),
        .dr_in    (dr),
        .inpr_in  (inpr),
        .ac_out   (ac),
        .e_out    (e)
    );

    function automatic logic [16:0] ref_step(logic [15:0] a, logic fe, logic [6:0] c,
                                             logic [15:0] d, logic [7:0] b, logic ci);
        case (c)
            C_AND:   return {fe, a & d};
            C_ADD:   return {1'b0, a} + {1'b0, d} + {16'b0, ci};
            C_DR:    return {fe, d};
            C_IN:    return {fe, 8'h00, b};
            C_COM:   return {fe, ~a};
            C_SHR:   return {a[0], fe, a[15:1]};
            C_SHL:   return {a[15], a[14:0], fe};
            default: return {fe, 16'h0000};
        endcase
    endfunction

    task automatic check(string req, logic [16:0] act, logic [16:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got {E,AC}=%05h expected %05h", req, act, exp);
        end
    endtask

    // drive at falling edge, result visible at the following falling edge
    task automatic step(logic l, logic [6:0] c, logic [15:0] d, logic [7:0] b, logic ci);
        @(negedge clk);
        ld = l; ctl = c; dr = d; inpr = b; cin = ci;
        @(negedge clk);
        ld = 1'b0; ctl = '0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", {e, ac}, 17'h0);

        // table walk with running reference state
        m_ac = '0; m_e = 1'b0;
        for (int k = 0; k < NV; k++) begin
            logic [16:0] nx;
            nx = ref_step(m_ac, m_e, V_CTL[k], V_DR[k], V_IN[k], V_CIN[k]);
            step(1'b1, V_CTL[k], V_DR[k], V_IN[k], V_CIN[k]);
            check(V_REQ[k], {e, ac}, nx);
            m_e = nx[16]; m_ac = nx[15:0];
        end

        // directed corner cases with hand-worked values
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset after use", {e, ac}, 17'h0);
        step(1'b1, C_DR, 16'hA35F, 8'h00, 1'b0);
        check("R5 copy", {e, ac}, {1'b0, 16'hA35F});
        step(1'b1, C_ADD, 16'h2A45, 8'h00, 1'b0);
        check("R4 add no carry", {e, ac}, {1'b0, 16'hCDA4});
        step(1'b1, C_ADD, 16'h8000, 8'h00, 1'b1);
        check("R4 add carry out", {e, ac}, {1'b1, 16'h4DA5});
        step(1'b1, C_SHR, 16'hFFFF, 8'hFF, 1'b1);
        check("R8 rotr through E", {e, ac}, {1'b1, 16'hA6D2});
        step(1'b1, C_SHL, 16'h0000, 8'h00, 1'b0);
        check("R9 rotl through E", {e, ac}, {1'b1, 16'h4DA5});
        step(1'b1, C_COM, 16'h0000, 8'h00, 1'b0);
        check("R7 invert keeps E", {e, ac}, {1'b1, 16'hB25A});
        step(1'b1, C_IN, 16'hFFFF, 8'h3C, 1'b1);
        check("R6 byte clears top", {e, ac}, {1'b1, 16'h003C});
        step(1'b1, C_AND, 16'h00F0, 8'hFF, 1'b1);
        check("R3 and", {e, ac}, {1'b1, 16'h0030});
        step(1'b0, C_DR, 16'hFFFF, 8'hFF, 1'b1);
        check("R2 hold with ld low", {e, ac}, {1'b1, 16'h0030});
        step(1'b0, C_ADD, 16'hFFFF, 8'hFF, 1'b1);
        check("R2 hold add ld low", {e, ac}, {1'b1, 16'h0030});
        step(1'b1, 7'b0, 16'hFFFF, 8'hFF, 1'b1);
        check("R10 idle loads zero", {e, ac}, {1'b1, 16'h0000});
        @(negedge clk); rst = 1'b1; ld = 1'b1; ctl = C_DR; dr = 16'hFFFF;
        @(negedge clk); rst = 1'b0; ld = 1'b0; ctl = '0;
        check("R1 reset beats load", {e, ac}, 17'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule